// File: doc/BRIEF.md
# Shift-and-Store Bus Register

This block takes a serial bit stream into a chain of flip-flop stages that advances on every rising clock edge. Beside the chain sits a second rank, one bit per stage, which captures the chain while a strobe input is high and holds it while the strobe is low. The held word drives a parallel bus through three-state buffers controlled by an output enable, so several of these registers can share one set of bus lines.

Two serial outputs carry the last stage onward for cascading. One changes with the rising edge. The other repeats the same bit half a clock later, on the falling edge, which gives the next register in a chain extra hold margin when clock edges are slow. The width is a parameter with a default of 8. An active-low reset clears the chain, the held word and the falling-edge output at once. Its release is synchronised to the clock.

Top module: `shift_store_reg`

## Requirements
- R1: On each rising clock edge the chain shifts by one stage toward the serial outputs, and `ser_in` enters stage 1, which drives `par_q[0]`.
- R2: While `strobe` is high, the held word equals the chain and follows each new shift within the same cycle.
- R3: While `strobe` is low, the held word keeps its value through any number of shifts.
- R4: While `out_en` is high, `par_q[i]` drives held bit i, where bit 0 is the stage nearest `ser_in` and bit WIDTH-1 is the last stage.
- R5: While `out_en` is low, every bit of `par_q` is high-impedance. `out_en` has no effect on `ser_rise` or `ser_fall`, which are always driven.
- R6: `ser_rise` equals the last stage and changes only on the rising clock edge.
- R7: `ser_fall` carries the bit that `ser_rise` presented and takes it on the following falling edge. Between a rising edge and the next falling edge it still shows the previous bit.
- R8: While `rst_n` is low, the chain, the held word, `ser_rise` and `ser_fall` are all 0, whatever the clock does. After `rst_n` rises, the first two rising edges shift nothing, and the third rising edge is the first to take `ser_in`.
- R9: Feeding a second register from either `ser_rise` or `ser_fall` of the first forms a 2*WIDTH-stage chain. The second register holds the older WIDTH bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; the chain moves on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| ser_in | input | 1 | Serial data into stage 1 |
| strobe | input | 1 | High: held word follows the chain; low: held word keeps its value |
| out_en | input | 1 | High: parallel bus driven; low: parallel bus high-impedance |
| par_q | output | WIDTH | Three-state parallel view of the held word |
| ser_rise | output | 1 | Last stage, updated on the rising edge |
| ser_fall | output | 1 | Last stage, re-timed to the falling edge |

## Verification
A corrupted chain bit shows at `ser_rise` within WIDTH rising edges, and at once on the parallel bus if the strobe is high. A held word that leaks while the strobe is low changes the enabled bus in the same cycle as the shift that disturbs it. A falling-edge stage that samples on the wrong edge shows up as `ser_fall` changing in the first half of a cycle. An enable that does not release the bus leaves a bus with a pull-up or a pull-down at a driven value rather than at the pull level.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  parameter int unsigned SSR_WIDTH_DEFAULT = 8;
  parameter int unsigned SSR_SYNC_DEPTH    = 2;
endpackage

// File: rtl/ssr_rst_sync.sv
module ssr_rst_sync #(
  parameter int unsigned DEPTH = ssr_pkg::SSR_SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[DEPTH-1];
endmodule

// File: rtl/ssr_shift_chain.sv
module ssr_shift_chain #(
  parameter int unsigned WIDTH = ssr_pkg::SSR_WIDTH_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_in,
  output logic [WIDTH-1:0] stages_o
);
  logic [WIDTH-1:0] stg_q;
  logic [WIDTH-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[WIDTH-2:0], shift_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign stages_o = stg_q;

  // R1: the bit sampled at one edge sits in stage 1 after the next
  assert_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (stg_q[0] == $past(shift_in)));
endmodule

// File: rtl/ssr_store_latch.sv
module ssr_store_latch #(
  parameter int unsigned WIDTH = ssr_pkg::SSR_WIDTH_DEFAULT
) (
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] store_o
);
  logic [WIDTH-1:0] hold_q;

  always_latch begin
    if (!rst_n)      hold_q <= '0;
    else if (strobe) hold_q <= din;
  end

  assign store_o = hold_q;
endmodule

// File: rtl/ssr_fall_stage.sv
module ssr_fall_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic q_r;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= d;
  end

  assign q = q_r;

  // R7: by each rising edge the re-timed copy has caught up with its source
  assert_fall_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_r == d);
endmodule

// File: rtl/shift_store_reg.sv
module shift_store_reg #(
  parameter int unsigned WIDTH = ssr_pkg::SSR_WIDTH_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             strobe,
  input  logic             out_en,
  output logic [WIDTH-1:0] par_q,
  output logic             ser_rise,
  output logic             ser_fall
);
  localparam int unsigned LAST = WIDTH - 1;

  logic             rst_sync_n;
  logic [WIDTH-1:0] chain;
  logic [WIDTH-1:0] held;

  ssr_rst_sync #(.DEPTH(ssr_pkg::SSR_SYNC_DEPTH)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ssr_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_in (ser_in),
    .stages_o (chain)
  );

  ssr_store_latch #(.WIDTH(WIDTH)) u_store (
    .rst_n   (rst_sync_n),
    .strobe  (strobe),
    .din     (chain),
    .store_o (held)
  );

  ssr_fall_stage u_fall (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (chain[LAST]),
    .q     (ser_fall)
  );

  assign ser_rise = chain[LAST];

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bus_drv
    assign par_q[gi] = out_en ? held[gi] : 1'bz;
  end

  // R2: an open strobe leaves the held word equal to the chain
  assert_follow_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    strobe |-> (held == chain));

  // R3: a closed strobe freezes the held word across shifts
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!strobe && !$past(strobe)) |-> $stable(held));

  // R8: nothing leaves reset non-zero
  assert_reset_clear_R8: assert property (@(posedge clk)
    !rst_sync_n |-> (chain == '0 && held == '0 && !ser_fall));
endmodule

// File: tb/shift_store_reg_tb.sv
module shift_store_reg_tb;
  localparam int W          = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, ser_in, strobe, out_en;
  wire  [W-1:0] par_a, bus_r, bus_f;
  wire  rise_a, fall_a, rise_r, fall_r, rise_f, fall_f;

  int n_vec = 0;
  int n_bad = 0;

  logic [2*W-1:0] chain;
  logic [W-1:0]   st_a, st_b;
  logic           fall_prev;
  int             sync_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_store_reg #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .strobe(strobe), .out_en(out_en),
    .par_q(par_a), .ser_rise(rise_a), .ser_fall(fall_a));

  shift_store_reg #(.WIDTH(W)) u_next_r (
    .clk(clk), .rst_n(rst_n), .ser_in(rise_a), .strobe(strobe), .out_en(out_en),
    .par_q(bus_r), .ser_rise(rise_r), .ser_fall(fall_r));

  shift_store_reg #(.WIDTH(W)) u_next_f (
    .clk(clk), .rst_n(rst_n), .ser_in(fall_a), .strobe(strobe), .out_en(out_en),
    .par_q(bus_f), .ser_rise(rise_f), .ser_fall(fall_f));

  for (genvar gi = 0; gi < W; gi++) begin : g_pulls
    pullup   (bus_r[gi]);
    pulldown (bus_f[gi]);
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive at the falling edge, model at the rising edge, compare a quarter later
  task automatic cyc(input string ctx, input logic d, input logic s, input logic o);
    @(negedge clk);
    #(CLK_PERIOD/8);
    chk({ctx, " R7 ser_fall after falling edge"}, {{(W-1){1'b0}}, fall_a}, {{(W-1){1'b0}}, chain[W-1]});
    ser_in = d; strobe = s; out_en = o;
    @(posedge clk);
    fall_prev = chain[W-1];
    if (sync_cnt < 2) sync_cnt++;
    else chain = {chain[2*W-2:0], d};
    #(CLK_PERIOD/4);
    if (sync_cnt < 2) begin
      st_a = '0; st_b = '0;
    end else if (s) begin
      st_a = chain[W-1:0]; st_b = chain[2*W-1:W];
    end
    chk({ctx, " R6 ser_rise"}, {{(W-1){1'b0}}, rise_a}, {{(W-1){1'b0}}, chain[W-1]});
    chk({ctx, " R7 ser_fall before falling edge"}, {{(W-1){1'b0}}, fall_a}, {{(W-1){1'b0}}, fall_prev});
    if (o) begin
      chk({ctx, " R4 par_q"}, par_a, st_a);
      chk({ctx, " R9 rise cascade word"}, bus_r, st_b);
      chk({ctx, " R9 fall cascade word"}, bus_f, st_b);
    end else begin
      chk({ctx, " R5 released bus (pull-up)"}, bus_r, '1);
      chk({ctx, " R5 released bus (pull-down)"}, bus_f, '0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    #(CLK_PERIOD/8);
    rst_n = 1'b0; ser_in = 1'b1; strobe = 1'b1; out_en = 1'b1;
    chain = '0; st_a = '0; st_b = '0; fall_prev = 1'b0; sync_cnt = 0;
    #(CLK_PERIOD/4);
    chk("R8 reset par_q", par_a, '0);
    chk("R8 reset cascade word", bus_r, '0);
    chk("R8 reset serial outs", {{(W-2){1'b0}}, rise_a, fall_a}, '0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #(CLK_PERIOD/8);
    chk("R8 reset held across edges", par_a, '0);
    rst_n = 1'b1;
    @(posedge clk);
    sync_cnt = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ser_in = 1'b0; strobe = 1'b0; out_en = 1'b0;
    do_reset();
    // R8: ser_in high during release, nothing enters on the first two edges
    cyc("R8 sync edge", 1'b1, 1'b1, 1'b1);
    cyc("R8 first shift", 1'b1, 1'b1, 1'b1);
    // R1: a single one walks up from bit 0, strobe open (R2)
    cyc("R1 walk", 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 10; i++) cyc("R1 R2 walk", 1'b0, 1'b1, 1'b1);
    // R3: closed strobe while shifting a 16-bit word through both ranks
    for (int i = 0; i < 2*W; i++) cyc("R3 hold", 1'(16'hC3A5 >> i), 1'b0, 1'b1);
    // R9: open the strobe to expose the full cascaded word
    cyc("R9 strobe", 1'b0, 1'b1, 1'b1);
    cyc("R9 strobe closed", 1'b1, 1'b0, 1'b1);
    // R5: bus released, serial outputs keep running
    for (int i = 0; i < 12; i++) cyc("R5 disabled", 1'(i % 3 == 0), 1'b1, 1'b0);
    cyc("R4 re-enabled", 1'b1, 1'b0, 1'b1);
    // R2: transparent strobe with alternating data
    for (int i = 0; i < 20; i++) cyc("R2 follow", 1'(i & 1), 1'b1, 1'b1);
    for (int i = 0; i < 6; i++)  cyc("R3 hold again", 1'b1, 1'b0, 1'b1);
    // R8: reset in mid-stream
    do_reset();
    cyc("R8 sync edge again", 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 2*W + 2; i++) cyc("R9 after reset", 1'(16'h1E69 >> (i % 16)), 1'b1, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule